// File: doc/BRIEF.md
# Serial Position Readout Port

This block is the read side of a position-measurement channel. A host pulls a chip-select line low and then toggles a serial clock; the port answers on one data line with a 16-bit word that holds three status flags, a sign and a 12-bit magnitude. The word is frozen when the select falls, so any position updates during the read leave it unchanged.

While the select is high the port releases the data line through a separate output-enable signal. Several ports can therefore share one data wire, with an external decoder choosing which one is selected. The select and serial clock arrive without any relation to the system clock. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies.

The host must wait a set number of system clocks after lowering the select before it gives the first serial-clock rise. That count is programmable. A port that sees a rise too early raises a sticky setup-error flag, which clears at the next select fall.

Top module: `ser_pos_port`

## Requirements
- R1: While the synchronised select is high, `sdo_oe` is 0 and `sdo` reads 0. After the select falls, `sdo_oe` is 1 until the select rises again.
- R2: On a select fall the port captures the word {flag_los, flag_ovr, flag_unr, pos_sign, pos_mag}. `sdo` reads 0 until the first serial-clock rise.
- R3: Each serial-clock rise while selected moves the next captured bit onto `sdo`, most significant bit first. Sixteen rises present the whole word.
- R4: Word layout: bit 15 is loss-of-signal, bit 14 is overrange, bit 13 is underrange, bit 12 is sign, and bits 11..0 are the magnitude with bit 11 first.
- R5: Serial-clock rises after the sixteenth present 0 for as long as the select stays low.
- R6: Changes on the flag and position inputs after the select falls do not alter the word being shifted.
- R7: Raising the select before all 16 bits ends the read. The next select fall captures a fresh word and starts again from bit 15.
- R8: A serial-clock rise seen fewer than `setup_limit` system clocks after the select fall sets `setup_err`. The flag stays set until the next select fall clears it. A read that waits long enough leaves it clear.
- R9: After reset, `sdo_oe`, `sdo` and `setup_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous chip select, active low |
| sclk_in | input | 1 | Asynchronous serial clock |
| flag_los | input | 1 | Loss-of-signal flag |
| flag_ovr | input | 1 | Overrange flag |
| flag_unr | input | 1 | Underrange flag |
| pos_sign | input | 1 | Position sign bit |
| pos_mag | input | 12 | Position magnitude |
| setup_limit | input | 16 | Minimum system clocks from select fall to first serial-clock rise |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the shared data line |
| setup_err | output | 1 | Sticky setup-violation flag |

## Verification
The assertions assume that every select and serial-clock level lasts several system clocks. Under that assumption each edge survives the synchroniser as a single clean event. They also assume that `setup_limit` does not change during a read.

The stimulus drives all inputs on falling system-clock edges. It holds each serial-clock phase for 13 system clocks, which is 260 ns and above the 250 ns minimum. It keeps the select high for 40 clocks between reads, and on compliant reads it waits 40 clocks (above a limit of 30) before the first rise. The one deliberate violation gives a rise five clocks after the select fall.

// File: rtl/ser_pkg.sv
// Shared widths and the layout of the status-plus-position word.
package ser_pkg;
    localparam int MAG_W  = 12;
    localparam int WORD_W = MAG_W + 4;
    localparam int CNT_W  = 16;

    // Shift order is fixed: the readers decode bits by position.
    typedef struct packed {
        logic             los;
        logic             ovr;
        logic             unr;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } pos_word_t;
endpackage

// File: rtl/ser_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous level inputs.
// Assumes each input level is held far longer than STAGES clocks.
module ser_sync #(
    parameter int W = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop: samples the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= din;
            end
        end else begin : g_next
            // Later flops: let any metastable value settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/ser_setup_guard.sv
// Counts system clocks since the select fall and flags any serial-clock
// rise that comes earlier than setup_limit. The flag is sticky until the
// next select fall. Assumes setup_limit is static during a read.
module ser_setup_guard
    import ser_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_evt,
    input  logic          selected,
    input  logic          sclk_rise,
    input  logic [CW-1:0] setup_limit,
    output logic          setup_err
);
    logic [CW-1:0] since_fall;

    // Saturating cycle count since the last select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_fall <= '0;
        else if (fall_evt)                 since_fall <= '0;
        else if (selected && since_fall != '1) since_fall <= since_fall + 1'b1;
    end

    // Sticky violation flag, cleared at the start of each read.
    always_ff @(posedge clk) begin
        if (!rst_n)        setup_err <= 1'b0;
        else if (fall_evt) setup_err <= 1'b0;
        else if (sclk_rise && selected && since_fall < setup_limit)
            setup_err <= 1'b1;
    end

    // R8: once set, the flag holds until a new select fall.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_err && !fall_evt |=> setup_err);
endmodule

// File: rtl/ser_shifter.sv
// Capture register and MSB-first shifter with output enable.
// A load freezes the word; each shift moves the top bit onto sdo and
// fills zeros from below. Assumes load and shift come from clean edges.
module ser_shifter
    import ser_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift_en,
    input  logic          deselect,
    input  logic [WW-1:0] word_in,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int SCW = $clog2(WW + 1);

    logic [WW-1:0]  shreg;
    logic [SCW-1:0] shift_cnt;
    logic           sdo_q;

    // Capture and shift path; load wins over a coincident shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            shreg <= word_in;
            sdo_q <= 1'b0;
        end else if (shift_en) begin
            sdo_q <= shreg[WW-1];
            shreg <= {shreg[WW-2:0], 1'b0};
        end
    end

    // Saturating count of bits shifted since the last load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    shift_cnt <= SCW'(WW);
        else if (load)                                 shift_cnt <= '0;
        else if (shift_en && shift_cnt != SCW'(WW))    shift_cnt <= shift_cnt + 1'b1;
    end

    // Output enable: on at capture, off as soon as the select is high.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo_oe <= 1'b0;
        else if (deselect) sdo_oe <= 1'b0;
        else if (load)     sdo_oe <= 1'b1;
    end

    // Data line reads zero whenever it is not driven.
    assign sdo = sdo_oe & sdo_q;

    // R3: a shift presents the previous top bit.
    a_r3_msb_out: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !load |=> sdo_q == $past(shreg[WW-1]));
    // R5: after a full word only zeros remain.
    a_r5_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
        shift_cnt == SCW'(WW) |-> shreg == '0);
    // R6: with no load or shift the captured word does not move.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !shift_en |=> $stable(shreg));
endmodule

// File: rtl/ser_pos_port.sv
// Three-wire serial readout port. It synchronises the select and the
// serial clock, detects their edges, captures the word on a select fall
// and shifts it out MSB first on serial-clock rises. Assumes the host
// keeps each select and serial-clock level for several system clocks.
module ser_pos_port
    import ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_in,
    input  logic             sclk_in,
    input  logic             flag_los,
    input  logic             flag_ovr,
    input  logic             flag_unr,
    input  logic             pos_sign,
    input  logic [MAG_W-1:0] pos_mag,
    input  logic [CNT_W-1:0] setup_limit,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             setup_err
);
    logic [1:0] sync_out;
    logic       cs_s, sclk_s, cs_prev, sclk_prev;
    logic       fall_evt, sclk_rise, selected;
    pos_word_t  live_word;

    ser_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n_in, sclk_in}),
        .dout (sync_out)
    );
    assign cs_s   = sync_out[1];
    assign sclk_s = sync_out[0];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign fall_evt  = cs_prev & ~cs_s;
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign selected  = ~cs_s;

    // Assemble the live status-plus-position word.
    always_comb begin
        live_word.los  = flag_los;
        live_word.ovr  = flag_ovr;
        live_word.unr  = flag_unr;
        live_word.sign = pos_sign;
        live_word.mag  = pos_mag;
    end

    ser_shifter #(.WW(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fall_evt),
        .shift_en(sclk_rise & selected),
        .deselect(cs_s),
        .word_in (live_word),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    ser_setup_guard #(.CW(CNT_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_evt   (fall_evt),
        .selected   (selected),
        .sclk_rise  (sclk_rise),
        .setup_limit(setup_limit),
        .setup_err  (setup_err)
    );

    // R1: a high select releases the line on the next clock.
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe);
    // R2: a select fall enables the line with zero before any shift.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> sdo_oe && !sdo);
    // R8: every read starts with a clear setup flag.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !setup_err);
endmodule

// File: tb/tb_ser_pos_port.sv
module tb_ser_pos_port;
    import ser_pkg::*;

    localparam int HALF = 13;   // serial-clock phase in system clocks
    localparam int GAP  = 40;   // select setup and idle time
    localparam int NV   = 6;
    localparam logic [15:0] VEC [NV] = '{
        16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001, 16'h4800, 16'h1ABC
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n_in = 1'b1, sclk_in = 1'b0;
    logic flag_los = 0, flag_ovr = 0, flag_unr = 0, pos_sign = 0;
    logic [MAG_W-1:0] pos_mag = '0;
    logic [CNT_W-1:0] setup_limit = 16'd30;
    logic sdo, sdo_oe, setup_err;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ser_pos_port dut (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic set_word(input logic [15:0] w);
        {flag_los, flag_ovr, flag_unr, pos_sign, pos_mag} = w;
    endtask

    task automatic bit_edge(output logic b);
        sclk_in = 1'b1; tick(HALF);
        b = sdo;
        sclk_in = 1'b0; tick(HALF);
    endtask

    task automatic select(); cs_n_in = 1'b0; tick(GAP); endtask
    task automatic deselect(); cs_n_in = 1'b1; tick(GAP); endtask

    initial begin
        logic b;
        logic [15:0] exp_w;
        tick(4);
        // R9: reset state
        chk("R9 oe", sdo_oe, 1'b0);
        chk("R9 sdo", sdo, 1'b0);
        chk("R9 err", setup_err, 1'b0);
        rst_n = 1'b1; tick(4);
        chk("R1 idle oe", sdo_oe, 1'b0);

        // R3/R4/R5: table of words, full reads plus trailing zeros
        for (int v = 0; v < NV; v++) begin
            set_word(VEC[v]);
            select();
            chk("R1 oe on", sdo_oe, 1'b1);
            chk("R2 zero before edge", sdo, 1'b0);
            for (int i = 0; i < 16; i++) begin
                bit_edge(b);
                chk("R3 R4 bit", b, VEC[v][15-i]);
            end
            for (int i = 0; i < 3; i++) begin
                bit_edge(b);
                chk("R5 tail zero", b, 1'b0);
            end
            chk("R8 no err", setup_err, 1'b0);
            deselect();
            chk("R1 oe off", sdo_oe, 1'b0);
            chk("R1 sdo off", sdo, 1'b0);
        end

        // R6: position changes during a read
        exp_w = 16'h6F0D;
        set_word(exp_w);
        select();
        for (int i = 0; i < 16; i++) begin
            if (i == 3) set_word(~exp_w);
            bit_edge(b);
            chk("R6 frozen word", b, exp_w[15-i]);
        end
        deselect();

        // R7: early release then fresh capture
        set_word(16'hC0F0);
        select();
        for (int i = 0; i < 5; i++) begin
            bit_edge(b);
            chk("R7 partial", b, exp_w[15-i] ^ exp_w[15-i] ^ 1'(16'hC0F0 >> (15-i)));
        end
        deselect();
        chk("R7 released", sdo_oe, 1'b0);
        exp_w = 16'h3A57;
        set_word(exp_w);
        select();
        for (int i = 0; i < 16; i++) begin
            bit_edge(b);
            chk("R7 fresh read", b, exp_w[15-i]);
        end
        deselect();

        // R8: early serial-clock rise
        set_word(16'h9000);
        cs_n_in = 1'b0; tick(5);
        bit_edge(b);
        chk("R8 err set", setup_err, 1'b1);
        chk("R8 bit still shifts", b, 1'b1);
        tick(20);
        chk("R8 err sticky", setup_err, 1'b1);
        deselect();
        select();
        chk("R8 cleared", setup_err, 1'b0);
        bit_edge(b);
        chk("R8 compliant read", setup_err, 1'b0);
        deselect();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule